// File: doc/BRIEF.md
# Page Staging Buffer with Deferred Array Commit

This block sits behind a two-wire serial memory protocol engine. During a write transaction the engine hands it a start address and then a stream of received data bytes. The bytes are held in a 16-entry page latch rather than written straight into storage. The latch keeps the page number fixed and moves only the 4-bit offset, which wraps inside the page.

When the engine reports the bus STOP condition, the block starts a self-timed program cycle. The block holds `busy` high for a fixed number of clock cycles, set by a parameter. In the first sixteen of those cycles it scans the latch and copies every entry that received data into a 2048 x 8 array model. The engine uses `busy` to stop acknowledging. A hardware write-protect input sampled at STOP can veto the commit.

A read port gives combinational access to the array contents. The array write strobe, address and data are also brought out, so that neighbouring logic can observe each committed byte.

Top module: `pgwr_commit`

## Requirements
- R1: After reset `busy` is 0 and `arr_we` is 0.
- R2: A `load_addr` pulse while idle sets the page (`addr_in[10:4]`) and the offset (`addr_in[3:0]`), and it empties the latch. The first following byte is destined for exactly `addr_in`.
- R3: After each accepted byte only the 4-bit offset advances, wrapping from 15 to 0. Address bits [10:4] of every committed byte equal the loaded page.
- R4: When more than 16 bytes arrive before STOP, a later byte replaces the one held at the same offset. The array receives the most recent byte for each offset.
- R5: Nothing reaches the array before STOP (`arr_we` stays 0 while bytes are loaded). A STOP with at least one byte and `wp` = 0 raises `busy` on the next cycle and holds it for exactly WR_CYCLES cycles.
- R6: A commit writes only the offsets that received data, one per cycle, in ascending offset order, at most 16 writes, and only while `busy` is 1. The other locations of the page keep their contents.
- R7: A STOP with no bytes since the last `load_addr` produces no `busy` period and no array write.
- R8: With `wp` = 1 at STOP the latched bytes are discarded: no `busy` period occurs, the array is unchanged, and a later STOP with no new bytes also commits nothing.
- R9: While `busy` is 1, `load_addr`, `byte_vld` and `stop_evt` are ignored. They neither extend the cycle nor reach the latch or the array.
- R10: A transaction with a single data byte is committed through the same cycle and writes only that one location.
- R11: `rd_data` shows the array byte at `rd_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_addr | input | 1 | Strobe: take `addr_in` as the transaction start address |
| addr_in | input | 11 | Start address: page in [10:4], offset in [3:0] |
| byte_vld | input | 1 | Strobe: one received data byte on `byte_data` |
| byte_data | input | 8 | Received data byte |
| stop_evt | input | 1 | Strobe: bus STOP condition seen |
| wp | input | 1 | Hardware write protect, sampled with `stop_evt` |
| busy | output | 1 | Self-timed program cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_waddr | output | 11 | Array write address |
| arr_wdata | output | 8 | Array write data |
| rd_addr | input | 11 | Array read address |
| rd_data | output | 8 | Array read data |

## Verification
The hardest situation to create from the ports is traffic that arrives while a program cycle is running. The block must drop it without letting it leak into the latch, lengthen the cycle or disturb the page being committed. To reach this, the bench issues a STOP and, while the cycle counter is still running, drives a complete second transaction: a new address, bytes and a STOP. It then checks that the cycle length is unchanged, that the target page still reads its earlier contents, and that a follow-up STOP starts nothing. Wrap-around is forced from the top page of the array with a start offset other than zero. Runs of 20 and 33 bytes make the overwrite order visible in the committed data.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
   typedef enum logic [0:0] {
      SQ_IDLE = 1'b0,
      SQ_PROG = 1'b1
   } seq_state_t;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/pgwr_latch.sv
module pgwr_latch #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8,
   parameter int PAGE_W = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic [ADDR_W-1:0]          addr,
   input  logic                       wr,
   input  logic [DATA_W-1:0]          din,
   input  logic                       clr,
   input  logic [PAGE_W-1:0]          sel_idx,
   output logic [ADDR_W-PAGE_W-1:0]   page_base,
   output logic                       any_valid,
   output logic                       sel_valid,
   output logic [DATA_W-1:0]          sel_data
);
   localparam int PAGE   = 1 << PAGE_W;
   localparam int BASE_W = ADDR_W - PAGE_W;

   logic [PAGE_W-1:0] ptr_q;
   logic [BASE_W-1:0] base_q;
   logic [PAGE-1:0]   ent_v;
   logic [DATA_W-1:0] ent_d [PAGE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         base_q <= '0;
      end else if (load) begin
         ptr_q  <= addr[PAGE_W-1:0];
         base_q <= addr[ADDR_W-1:PAGE_W];
      end else if (wr) begin
         ptr_q  <= ptr_q + 1'b1;
      end
   end

   for (genvar g = 0; g < PAGE; g++) begin : g_ent
      logic              v_q;
      logic [DATA_W-1:0] d_q;
      wire               hit = wr && (ptr_q == PAGE_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          v_q <= 1'b0;
         else if (clr || load) v_q <= 1'b0;
         else if (hit)         v_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (hit && !clr && !load) d_q <= din;
      end

      assign ent_v[g] = v_q;
      assign ent_d[g] = d_q;
   end

   assign page_base = base_q;
   assign any_valid = |ent_v;
   assign sel_valid = ent_v[sel_idx];
   assign sel_data  = ent_d[sel_idx];
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
   import pgwr_pkg::*;
#(
   parameter int PAGE_W    = 4,
   parameter int WR_CYCLES = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop,
   input  logic              wp,
   input  logic              any_valid,
   input  logic              sel_valid,
   output logic              busy,
   output logic [PAGE_W-1:0] scan_idx,
   output logic              do_write,
   output logic              clr_latch
);
   localparam int PAGE  = 1 << PAGE_W;
   localparam int CNT_W = cnt_width(WR_CYCLES);
   localparam logic [CNT_W-1:0] LAST   = CNT_W'(WR_CYCLES - 1);
   localparam logic [CNT_W-1:0] SCAN_N = CNT_W'(PAGE);

   seq_state_t       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             go;
   logic             at_end;

   assign go     = (st_q == SQ_IDLE) && stop && !wp && any_valid;
   assign at_end = (st_q == SQ_PROG) && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_IDLE;
         cnt_q <= '0;
      end else begin
         case (st_q)
            SQ_IDLE: begin
               cnt_q <= '0;
               if (go) st_q <= SQ_PROG;
            end
            SQ_PROG: begin
               cnt_q <= cnt_q + 1'b1;
               if (at_end) st_q <= SQ_IDLE;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy      = (st_q == SQ_PROG);
   assign scan_idx  = cnt_q[PAGE_W-1:0];
   assign do_write  = busy && (cnt_q < SCAN_N) && sel_valid;
   assign clr_latch = ((st_q == SQ_IDLE) && stop && !go) || at_end;
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 8,
   parameter bit RD_REG = 1'b0
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   if (RD_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rq;
      always_ff @(posedge clk) rq <= mem[raddr];
      assign rdata = rq;
   end else begin : g_rd_comb
      assign rdata = mem[raddr];
   end
endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit #(
   parameter int ADDR_W    = 11,
   parameter int DATA_W    = 8,
   parameter int PAGE_W    = 4,
   parameter int WR_CYCLES = 1000,
   parameter bit RD_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_addr,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              stop_evt,
   input  logic              wp,
   output logic              busy,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_waddr,
   output logic [DATA_W-1:0] arr_wdata,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int PAGE   = 1 << PAGE_W;
   localparam int BASE_W = ADDR_W - PAGE_W;

   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("pgwr_commit: PAGE_W must lie in 1..ADDR_W-1");
   end
   if (WR_CYCLES < PAGE) begin : g_bad_cycles
      $error("pgwr_commit: WR_CYCLES must cover one scan of the page");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("pgwr_commit: DATA_W must be positive");
   end

   logic              seq_busy;
   logic [PAGE_W-1:0] scan_idx;
   logic              do_write;
   logic              clr_latch;
   logic [BASE_W-1:0] page_base;
   logic              any_valid;
   logic              sel_valid;
   logic [DATA_W-1:0] sel_data;

   pgwr_latch #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .PAGE_W (PAGE_W)
   ) u_latch (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_addr && !seq_busy),
      .addr      (addr_in),
      .wr        (byte_vld && !seq_busy),
      .din       (byte_data),
      .clr       (clr_latch),
      .sel_idx   (scan_idx),
      .page_base (page_base),
      .any_valid (any_valid),
      .sel_valid (sel_valid),
      .sel_data  (sel_data)
   );

   pgwr_seq #(
      .PAGE_W    (PAGE_W),
      .WR_CYCLES (WR_CYCLES)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .stop      (stop_evt),
      .wp        (wp),
      .any_valid (any_valid),
      .sel_valid (sel_valid),
      .busy      (seq_busy),
      .scan_idx  (scan_idx),
      .do_write  (do_write),
      .clr_latch (clr_latch)
   );

   pgwr_array #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .RD_REG (RD_REG)
   ) u_array (
      .clk   (clk),
      .we    (do_write),
      .waddr ({page_base, scan_idx}),
      .wdata (sel_data),
      .raddr (rd_addr),
      .rdata (rd_data)
   );

   assign busy      = seq_busy;
   assign arr_we    = do_write;
   assign arr_waddr = {page_base, scan_idx};
   assign arr_wdata = sel_data;
endmodule

// File: rtl/pgwr_commit_chk.sv
module pgwr_commit_chk #(
   parameter int ADDR_W    = 11,
   parameter int PAGE_W    = 4,
   parameter int WR_CYCLES = 1000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop_evt,
   input logic              wp,
   input logic              busy,
   input logic              arr_we,
   input logic [ADDR_W-1:0] arr_waddr
);
   localparam int PAGE  = 1 << PAGE_W;
   localparam int LEN_W = $clog2(WR_CYCLES + 2);
   localparam int WC_W  = $clog2(PAGE + 2);

   logic [LEN_W-1:0]         blen;
   logic [WC_W-1:0]          wcnt;
   logic                     seen;
   logic [PAGE_W-1:0]        last_off;
   logic [ADDR_W-PAGE_W-1:0] last_pg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blen     <= '0;
         wcnt     <= '0;
         seen     <= 1'b0;
         last_off <= '0;
         last_pg  <= '0;
      end else if (!busy) begin
         blen <= '0;
         wcnt <= '0;
         seen <= 1'b0;
      end else begin
         blen <= blen + 1'b1;
         if (arr_we) begin
            wcnt     <= wcnt + 1'b1;
            seen     <= 1'b1;
            last_off <= arr_waddr[PAGE_W-1:0];
            last_pg  <= arr_waddr[ADDR_W-1:PAGE_W];
         end
      end
   end

   // R1, R5: no array write outside a program cycle
   assert_we_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);

   // R5: a cycle only begins after an unprotected STOP
   assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_evt && !wp));

   // R5, R9: program cycle length is exact
   assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (blen == LEN_W'(WR_CYCLES)));

   // R8: protected STOP starts nothing
   assert_wp_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && wp && !busy) |=> !busy);

   // R6: at most one page of writes per cycle
   assert_write_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> (wcnt < WC_W'(PAGE)));

   // R6: ascending offsets within a cycle
   assert_write_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && seen) |-> (arr_waddr[PAGE_W-1:0] > last_off));

   // R3: page bits stay fixed across one commit
   assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_we && seen) |-> (arr_waddr[ADDR_W-1:PAGE_W] == last_pg));
endmodule

bind pgwr_commit pgwr_commit_chk #(
   .ADDR_W    (ADDR_W),
   .PAGE_W    (PAGE_W),
   .WR_CYCLES (WR_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .stop_evt  (stop_evt),
   .wp        (wp),
   .busy      (busy),
   .arr_we    (arr_we),
   .arr_waddr (arr_waddr)
);

// File: tb/test_pgwr_commit.sv
module test_pgwr_commit;
   localparam int WR = 24;

   typedef struct packed {
      logic [10:0] a;
      logic [5:0]  n;
      logic [7:0]  d0;
      logic        p;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{11'h000, 6'd16, 8'h10, 1'b0},   // full page
      '{11'h005, 6'd1,  8'hA5, 1'b0},   // single byte (R10)
      '{11'h00E, 6'd4,  8'h31, 1'b0},   // wrap 14,15,0,1 (R3)
      '{11'h7F3, 6'd20, 8'h47, 1'b0},   // overflow on top page (R4)
      '{11'h123, 6'd5,  8'h99, 1'b1},   // protected (R8)
      '{11'h120, 6'd16, 8'h02, 1'b0},   // fill page
      '{11'h126, 6'd3,  8'hC0, 1'b0},   // partial update (R6)
      '{11'h3A0, 6'd0,  8'h00, 1'b0},   // no data (R7)
      '{11'h3AF, 6'd33, 8'h5B, 1'b0}    // double wrap (R4)
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_addr = 1'b0;
   logic [10:0] addr_in = '0;
   logic        byte_vld = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        stop_evt = 1'b0;
   logic        wp = 1'b0;
   logic        busy;
   logic        arr_we;
   logic [10:0] arr_waddr;
   logic [7:0]  arr_wdata;
   logic [10:0] rd_addr = '0;
   logic [7:0]  rd_data;

   int nchk = 0;
   int nerr = 0;

   logic [7:0] shm [2048];
   bit         known [2048];

   always #4 clk = ~clk;

   pgwr_commit #(.WR_CYCLES(WR)) i_pgwr_commit (
      .clk(clk), .rst_n(rst_n), .load_addr(load_addr), .addr_in(addr_in),
      .byte_vld(byte_vld), .byte_data(byte_data), .stop_evt(stop_evt), .wp(wp),
      .busy(busy), .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_load(input logic [10:0] a);
      @(negedge clk); load_addr = 1'b1; addr_in = a;
      @(negedge clk); load_addr = 1'b0;
   endtask

   task automatic do_byte(input logic [7:0] d);
      @(negedge clk); byte_vld = 1'b1; byte_data = d;
      @(negedge clk); byte_vld = 1'b0;
      chk(arr_we == 1'b0, "R5 no write before STOP", int'(arr_we), 0);
   endtask

   // Pulse STOP, then watch the whole program cycle.
   task automatic do_stop(input logic p, input bit exp_busy, input logic [6:0] pg,
                          input logic [15:0] exp_mask);
      int cnt = 0;
      int last = -1;
      bit order_ok = 1'b1;
      logic [15:0] got = '0;
      @(negedge clk); stop_evt = 1'b1; wp = p;
      @(negedge clk); stop_evt = 1'b0; wp = 1'b0;
      while (busy && cnt < 1000) begin
         if (arr_we) begin
            if (arr_waddr[10:4] != pg || int'(arr_waddr[3:0]) <= last) order_ok = 1'b0;
            last = int'(arr_waddr[3:0]);
            got[arr_waddr[3:0]] = 1'b1;
         end
         cnt++;
         @(negedge clk);
      end
      chk(cnt == (exp_busy ? WR : 0), "R5/R7/R8 busy length", cnt, exp_busy ? WR : 0);
      chk(order_ok, "R3/R6 write order and page", int'(order_ok), 1);
      chk(got == (exp_busy ? exp_mask : 16'h0), "R6 written offsets", int'(got),
          int'(exp_busy ? exp_mask : 16'h0));
   endtask

   task automatic check_page(input logic [6:0] pg, input string req);
      for (int o = 0; o < 16; o++) begin
         if (known[{pg, 4'(o)}]) begin
            rd_addr = {pg, 4'(o)};
            #1;
            chk(rd_data == shm[{pg, 4'(o)}], req, int'(rd_data), int'(shm[{pg, 4'(o)}]));
         end
      end
   endtask

   // Bench model of one transaction, built from the requirements.
   task automatic run_txn(input logic [10:0] a, input int n, input logic [7:0] d0,
                          input logic p, input string req);
      logic [7:0]  buf_d [16];
      logic [15:0] mask = '0;
      logic [3:0]  off = a[3:0];
      do_load(a);
      for (int k = 0; k < n; k++) begin
         logic [7:0] d = d0 + 8'(k * 13);
         buf_d[off] = d;
         mask[off] = 1'b1;
         do_byte(d);
         off = off + 4'd1;
      end
      do_stop(p, (n > 0) && !p, a[10:4], mask);
      if (!p) begin
         for (int o = 0; o < 16; o++) begin
            if (mask[o]) begin
               shm[{a[10:4], 4'(o)}] = buf_d[o];
               known[{a[10:4], 4'(o)}] = 1'b1;
            end
         end
      end
      check_page(a[10:4], req);
   endtask

   initial begin
      #(8 * 200000);
      nerr++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end

   initial begin
      for (int i = 0; i < 2048; i++) known[i] = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
      chk(arr_we == 1'b0, "R1 arr_we after reset", int'(arr_we), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1 busy idle", int'(busy), 0);

      // Vector table: R2 R3 R4 R6 R7 R8 R10 R11 readback through rd_data
      for (int v = 0; v < NV; v++) begin
         run_txn(VEC[v].a, int'(VEC[v].n), VEC[v].d0, VEC[v].p, "R2/R11 readback");
      end

      // R8: latch emptied by protected STOP; a bare STOP afterwards does nothing
      do_load(11'h240);
      do_byte(8'h77);
      do_stop(1'b1, 1'b0, 7'h24, 16'h0001);
      do_stop(1'b0, 1'b0, 7'h24, 16'h0000);

      // R9: traffic during a program cycle is ignored
      run_txn(11'h600, 16, 8'h21, 1'b0, "R9 preload");
      begin
         int cnt = 0;
         do_load(11'h500);
         do_byte(8'h3C);
         @(negedge clk); stop_evt = 1'b1;
         @(negedge clk); stop_evt = 1'b0;
         // inject a full transaction while busy
         load_addr = 1'b1; addr_in = 11'h604;
         @(negedge clk); load_addr = 1'b0;
         byte_vld = 1'b1; byte_data = 8'hEE;
         @(negedge clk); byte_vld = 1'b0;
         stop_evt = 1'b1;
         @(negedge clk); stop_evt = 1'b0;
         cnt = 3;
         while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
         chk(cnt == WR, "R9 cycle not extended", cnt, WR);
         shm[11'h500] = 8'h3C; known[11'h500] = 1'b1;
      end
      check_page(7'h60, "R9 page untouched");
      check_page(7'h50, "R10 single byte");
      do_stop(1'b0, 1'b0, 7'h60, 16'h0000);   // R9: ignored bytes never entered latch

      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end
endmodule